// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked control front end of a small synchronous SRAM. The storage is an internal register file of `DEPTH` words with byte lanes (16 words of two 8-bit lanes by default). On every rising clock edge the controller looks at two address strobes, three chip enables, a burst-advance input and the write controls. It then takes one of four actions: it deselects, starts a new burst at the presented address, steps the burst to its next address, or holds the current address.

There are two strobes. A strobe driven by a processor always opens a read. A strobe driven by a controller may open either a read or a write, because the write controls are sampled on its edge. The master chip enable gates only the processor strobe. A burst covers four addresses. The two low address bits follow either an XOR (interleaved) order or a wrapping increment (linear) order.

Read data leaves either through an output register, which adds one cycle, or directly from the array. A static mode pin selects between the two, and it is captured while reset is held. The output enable acts on the output immediately, with no clock involved. The bidirectional bus is split into a write-data input, a read-data output and an output-valid flag.

Top module: `sbs_ctrl`

## Requirements
- R1: While `rst_ni` is low, `rvalid_o` is 0 and every array word clears to 0. The output mode is captured from `ft_ni` during reset: 0 selects flow-through and 1 selects pipelined.
- R2: A processor start is `adsp_ni`=0 with `ce0_ni`=0. It loads `addr_i` as the burst base and always opens a read. No array word is written on that edge, whatever the write inputs are.
- R3: When `ce0_ni`=1, a low `adsp_ni` is ignored. An idle controller stays idle. A live burst continues or holds as if no strobe were present.
- R4: A controller start is `adsc_ni`=0 with no processor start on the same edge. It loads `addr_i`, and the write inputs are sampled on that edge, so the first beat writes `wdata_i` when any lane write is enabled.
- R5: A start from either strobe while not all enables are active (`ce0_ni`=0, `ce1_ni`=0, `ce2_i`=1) deselects the block and ends the burst. This includes a controller start with `ce0_ni`=1.
- R6: Lane i covers bits [8i+7:8i]. It is written when `gw_ni`=0, or when `bwe_ni`=0 and `bw_ni[i]`=0. With no lane enabled, the beat is a read.
- R7: The low 2 bits of the beat address are the base offset s combined with the beat count c. The result is s XOR c when `order_lin_i`=0 and (s+c) mod 4 when `order_lin_i`=1. The upper address bits stay fixed for the whole burst.
- R8: On an edge with no effective start during a live burst, `adv_ni`=0 steps the count and `adv_ni`=1 repeats the current address. The beat is a write if a lane write is enabled or if the previous beat was a write.
- R9: In pipelined mode, read data for a beat whose address is registered on edge k is valid after edge k+1.
- R10: In flow-through mode, read data for a beat whose address is registered on edge k is valid after edge k itself.
- R11: In the cycle after an edge that writes any lane, `rvalid_o` is 0 whatever `oe_ni` is.
- R12: `rvalid_o` is 1 only while `oe_ni`=0, and it follows `oe_ni` with no clock edge needed.
- R13: After a deselect on edge k, with no new start on edge k+1, `rvalid_o` is 0 after edge k+1. In flow-through mode it is already 0 after edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ft_ni | input | 1 | Output mode, captured in reset: 0 flow-through, 1 pipelined |
| order_lin_i | input | 1 | Burst order: 0 XOR, 1 linear |
| addr_i | input | AW | Word address, loaded on a start |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce0_ni | input | 1 | Master chip enable, active low |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| gw_ni | input | 1 | Write all lanes, active low |
| bwe_ni | input | 1 | Per-lane write qualifier, active low |
| bw_ni | input | LANES | Per-lane write strobes, active low |
| oe_ni | input | 1 | Output enable, active low, not clocked |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, 0 when not valid |
| rvalid_o | output | 1 | Read data is being driven |

## Verification
Each result falls due at a fixed edge, counted from the edge that registers the beat address. A write lands in the array on the edge that issues it. Read data appears after the same edge in flow-through mode and after the following edge in pipelined mode. Write blocking and deselect clear the output one edge later, and the output enable takes effect with no edge at all. The bench drives inputs 1 ns after a rising edge and samples outputs at that same point, after the edge the requirement names. For each beat it selects the expected word by shifting the beat index by the mode latency, and it looks that word up in a reference array that it updates whenever a write beat is issued.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  typedef enum logic {OUT_FLOW = 1'b0, OUT_PIPE = 1'b1} out_mode_e;
  typedef enum logic {ORD_XOR = 1'b0, ORD_LIN = 1'b1} burst_ord_e;
endpackage

// File: rtl/sbs_burst_seq.sv
`timescale 1ns/1ps
module sbs_burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0]   start_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  sbs_pkg::burst_ord_e ord_i,
  output logic [CNT_W-1:0]   off_o
);
  always_comb begin
    if (ord_i == sbs_pkg::ORD_LIN) off_o = start_i + cnt_i;
    else                           off_o = start_i ^ cnt_i;
  end
endmodule

// File: rtl/sbs_lane_mem.sv
`timescale 1ns/1ps
module sbs_lane_mem #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int e = 0; e < DEPTH; e++) arr[e] <= '0;
      end else if (we_i[l]) begin
        arr[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end
    assign rdata_o[l*LANE_W +: LANE_W] = arr[raddr_i];
  end
endmodule

// File: rtl/sbs_decode.sv
`timescale 1ns/1ps
module sbs_decode #(
  parameter int LANES = 2
) (
  input  logic             adsp_ni,
  input  logic             adsc_ni,
  input  logic             adv_ni,
  input  logic             ce0_ni,
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             act_i,
  input  logic             wr_i,
  output logic             load_o,
  output logic             desel_o,
  output logic             step_o,
  output logic             act_o,
  output logic             wr_o,
  output logic [LANES-1:0] lane_we_o
);
  logic [LANES-1:0] lane_req;
  logic p_go, any_go, sel_ok;

  always_comb begin
    lane_req  = {LANES{!gw_ni}} | ({LANES{!bwe_ni}} & ~bw_ni);
    p_go      = !adsp_ni && !ce0_ni;     // master enable gates only the processor strobe
    any_go    = p_go || !adsc_ni;
    sel_ok    = !ce0_ni && !ce1_ni && ce2_i;
    load_o    = 1'b0;
    desel_o   = 1'b0;
    step_o    = 1'b0;
    act_o     = 1'b0;
    wr_o      = 1'b0;
    lane_we_o = '0;
    if (any_go && !sel_ok) begin
      desel_o = 1'b1;
    end else if (any_go) begin
      load_o = 1'b1;
      act_o  = 1'b1;
      if (!p_go) begin
        wr_o      = |lane_req;
        lane_we_o = lane_req;
      end
    end else if (act_i) begin
      act_o     = 1'b1;
      step_o    = !adv_ni;
      wr_o      = wr_i || (|lane_req);
      lane_we_o = lane_req;
    end
  end
endmodule

// File: rtl/sbs_ctrl.sv
`timescale 1ns/1ps
module sbs_ctrl #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ft_ni,
  input  logic             order_lin_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             adsp_ni,
  input  logic             adsc_ni,
  input  logic             adv_ni,
  input  logic             ce0_ni,
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             oe_ni,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);
  import sbs_pkg::*;

  out_mode_e        mode_q;
  logic             act_q, wr_q, beat_rd_q, pipe_vld_q, wblk_q;
  logic [AW-1:0]    base_q, base_n, beat_addr_q, beat_addr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, off;
  logic [DW-1:0]    mem_rd, pipe_data_q;
  logic             load, desel, step, act_n, wr_n, out_vld;
  logic [LANES-1:0] mem_we;

  sbs_decode #(.LANES(LANES)) u_dec (
    .adsp_ni(adsp_ni), .adsc_ni(adsc_ni), .adv_ni(adv_ni),
    .ce0_ni(ce0_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i),
    .gw_ni(gw_ni), .bwe_ni(bwe_ni), .bw_ni(bw_ni),
    .act_i(act_q), .wr_i(wr_q),
    .load_o(load), .desel_o(desel), .step_o(step),
    .act_o(act_n), .wr_o(wr_n), .lane_we_o(mem_we)
  );

  always_comb begin
    base_n = load ? addr_i : base_q;
    cnt_n  = load ? '0 : cnt_q + {{(CNT_W-1){1'b0}}, step};
  end

  sbs_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .start_i(base_n[CNT_W-1:0]), .cnt_i(cnt_n),
    .ord_i(burst_ord_e'(order_lin_i)), .off_o(off)
  );

  assign beat_addr_n = {base_n[AW-1:CNT_W], off};

  sbs_lane_mem #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we),
    .waddr_i(beat_addr_n), .wdata_i(wdata_i),
    .raddr_i(beat_addr_q), .rdata_o(mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= out_mode_e'(ft_ni);  // static pin, captured while in reset
      act_q       <= 1'b0;
      wr_q        <= 1'b0;
      base_q      <= '0;
      cnt_q       <= '0;
      beat_addr_q <= '0;
      beat_rd_q   <= 1'b0;
      pipe_data_q <= '0;
      pipe_vld_q  <= 1'b0;
      wblk_q      <= 1'b0;
    end else begin
      act_q       <= act_n;
      wr_q        <= wr_n;
      base_q      <= base_n;
      cnt_q       <= cnt_n;
      beat_addr_q <= beat_addr_n;
      beat_rd_q   <= act_n && !wr_n;
      pipe_data_q <= mem_rd;
      pipe_vld_q  <= beat_rd_q;
      wblk_q      <= |mem_we;
    end
  end

  always_comb begin
    out_vld  = (mode_q == OUT_PIPE) ? pipe_vld_q : beat_rd_q;
    rvalid_o = out_vld && !wblk_q && !oe_ni;
    rdata_o  = !rvalid_o ? '0 : ((mode_q == OUT_PIPE) ? pipe_data_q : mem_rd);
  end

  // R2
  pstart_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && !ce0_ni) |-> (mem_we == '0));

  // R3
  ce0_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && ce0_ni && adsc_ni) |=> !act_q);

  // R8
  susp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && adsc_ni && (adsp_ni || ce0_ni) && adv_ni) |=> $stable(beat_addr_q));

  // R11
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_we) |=> !rvalid_o);

  // R13
  desel_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel ##1 (adsc_ni && (adsp_ni || ce0_ni)) |=> !rvalid_o);
endmodule

// File: tb/sbs_ctrl_test.sv
`timescale 1ns/1ps
module sbs_ctrl_test;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ft_ni = 1'b1, order_lin = 1'b0;
  logic [AW-1:0] addr = '0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic ce0_n = 1'b0, ce1_n = 1'b0, ce2 = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [1:0] bw_n = 2'b11;
  logic [DW-1:0] wdata = '0, rdata;
  logic rvalid;

  int total = 0, bad = 0;
  bit pipe = 1'b1;
  logic [DW-1:0] ref_mem [16];

  always #2 clk = ~clk;

  sbs_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .ft_ni(ft_ni), .order_lin_i(order_lin),
    .addr_i(addr), .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n),
    .ce0_ni(ce0_n), .ce1_ni(ce1_n), .ce2_i(ce2), .gw_ni(gw_n), .bwe_ni(bwe_n),
    .bw_ni(bw_n), .oe_ni(oe_n), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    ce0_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11; oe_n = 1'b0;
  endtask

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int seqa(int base, bit lin, int c);
    int lo = base & 3;
    int off = lin ? ((lo + c) & 3) : (lo ^ c);
    return (base & ~3) | off;
  endfunction

  task automatic chk_beat(int a, string req);
    chk({req, " valid"}, {15'd0, rvalid}, 16'd1);
    chk({req, " data"}, rdata, ref_mem[a]);
  endtask

  task automatic do_reset(bit ft);
    idle();
    rst_ni = 1'b0; ft_ni = ft; pipe = ft;
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    tick(); tick();
    // R1: no read data while held in reset
    chk("R1 reset valid", {15'd0, rvalid}, 16'd0);
    rst_ni = 1'b1;
    tick();
    chk("R1 after reset valid", {15'd0, rvalid}, 16'd0);
  endtask

  // R4 controller start writes first beat; R8 stepping write beats
  task automatic wr_burst(int base, bit lin, logic [DW-1:0] seed);
    order_lin = lin;
    addr = AW'(base); adsc_n = 1'b0; gw_n = 1'b0; wdata = seed;
    ref_mem[seqa(base, lin, 0)] = seed;
    tick();
    adsc_n = 1'b1;
    for (int j = 1; j < 4; j++) begin
      adv_n = 1'b0; wdata = seed + DW'(j);
      ref_mem[seqa(base, lin, j)] = seed + DW'(j);
      tick();
    end
    idle();
    tick();
  endtask

  // R7 order, R9/R10 latency, R8 advance and hold
  task automatic rd_burst(int base, bit lin);
    order_lin = lin;
    addr = AW'(base); adsp_n = 1'b0;
    tick();
    adsp_n = 1'b1;
    if (!pipe) chk_beat(seqa(base, lin, 0), "R10 R7 beat0");
    for (int j = 1; j < 4; j++) begin
      adv_n = 1'b0;
      tick();
      chk_beat(seqa(base, lin, pipe ? j - 1 : j), pipe ? "R9 R7 beat" : "R10 R7 beat");
    end
    adv_n = 1'b1;
    tick();
    chk_beat(seqa(base, lin, 3), "R8 hold beat3");
    tick();
    chk_beat(seqa(base, lin, 3), "R8 hold repeat");
  endtask

  task automatic start_read(int a);
    addr = AW'(a); adsp_n = 1'b0;
    tick();
    adsp_n = 1'b1;
    tick();
  endtask

  // R5 deselect per enable, R13 single-cycle release
  task automatic t_desel(int sel);
    start_read(sel + 1);
    chk_beat(sel + 1, "R5 pre-deselect read");
    case (sel)
      0: begin adsc_n = 1'b0; ce0_n = 1'b1; end
      1: begin adsc_n = 1'b0; ce1_n = 1'b1; end
      2: begin adsc_n = 1'b0; ce2 = 1'b0; end
      default: begin adsp_n = 1'b0; ce1_n = 1'b1; end
    endcase
    tick();
    idle();
    if (pipe) chk_beat(sel + 1, "R13 last piped beat");
    else chk("R13 flow off at once", {15'd0, rvalid}, 16'd0);
    tick();
    chk("R5 R13 deselected", {15'd0, rvalid}, 16'd0);
    tick();
    chk("R5 stays deselected", {15'd0, rvalid}, 16'd0);
  endtask

  task automatic t_lanes();
    order_lin = 1'b0;
    // lane0 only: bits [7:0]
    addr = 4'd5; adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b10; wdata = 16'hABCD;
    ref_mem[5] = {ref_mem[5][15:8], 8'hCD};
    tick();
    idle(); tick();
    start_read(5);
    chk_beat(5, "R6 lane0 only");
    // lane1 only: bits [15:8]
    addr = 4'd4; adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b01; wdata = 16'h3C77;
    ref_mem[4] = {8'h3C, ref_mem[4][7:0]};
    tick();
    idle(); tick();
    start_read(4);
    chk_beat(4, "R6 lane1 only");
    // lane strobes without qualifier: read beat, no write
    addr = 4'd6; adsc_n = 1'b0; bwe_n = 1'b1; bw_n = 2'b00; wdata = 16'h0BAD;
    tick();
    idle();
    if (pipe) tick();
    chk_beat(6, "R6 R4 no-lane read");
  endtask

  task automatic t_adsp_nowr();
    addr = 4'd7; adsp_n = 1'b0; gw_n = 1'b0; wdata = 16'hFFFF;
    tick();
    idle();
    if (pipe) tick();
    chk_beat(7, "R2 processor start reads");
    start_read(7);
    chk_beat(7, "R2 word unchanged");
  endtask

  task automatic t_ce0_block();
    order_lin = 1'b0;
    start_read(8);
    addr = 4'd0; adsp_n = 1'b0; ce0_n = 1'b1; adv_n = 1'b0;
    tick();
    idle();
    tick();
    chk_beat(9, "R3 blocked strobe, burst steps");
    addr = 4'd1; adsc_n = 1'b0; ce1_n = 1'b1;
    tick(); idle(); tick();
    addr = 4'd2; adsp_n = 1'b0; ce0_n = 1'b1;
    tick(); idle(); tick();
    chk("R3 idle stays idle", {15'd0, rvalid}, 16'd0);
  endtask

  task automatic t_wblk();
    order_lin = 1'b0;
    start_read(3);
    chk_beat(3, "R11 pre-write read");
    bwe_n = 1'b0; bw_n = 2'b01; adv_n = 1'b0; wdata = 16'h5A00;
    ref_mem[2] = {8'h5A, ref_mem[2][7:0]};
    tick();
    idle();
    chk("R11 write blocks output", {15'd0, rvalid}, 16'd0);
    tick();
    chk("R8 write direction kept", {15'd0, rvalid}, 16'd0);
    start_read(2);
    chk_beat(2, "R11 R6 written lane1");
  endtask

  task automatic t_oe();
    start_read(10);
    chk_beat(10, "R12 oe low");
    oe_n = 1'b1; #1;
    chk("R12 oe high", {15'd0, rvalid}, 16'd0);
    oe_n = 1'b0; #1;
    chk_beat(10, "R12 oe low again");
  endtask

  task automatic run_mode(bit ft);
    do_reset(ft);
    start_read(0);
    chk_beat(0, "R1 cleared word");
    wr_burst(0, 1'b0, 16'h1100);
    wr_burst(6, 1'b1, 16'h2200);
    wr_burst(9, 1'b0, 16'h3300);
    wr_burst(15, 1'b1, 16'h4400);
    rd_burst(1, 1'b0);
    rd_burst(2, 1'b1);
    rd_burst(13, 1'b0);
    rd_burst(11, 1'b1);
    t_lanes();
    t_adsp_nowr();
    t_ce0_block();
    for (int s = 0; s < 4; s++) t_desel(s);
    t_wblk();
    t_oe();
  endtask

  initial begin
    run_mode(1'b1);
    run_mode(1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule